// File: doc/BRIEF.md
# Double-Data-Rate Write Burst Driver

This block produces the write-side pin waveforms of a double-data-rate memory interface: the data lanes, the byte mask lanes and the data strobe, together with output enables for each group. It runs on a clock at twice the interface rate, so one tick of `clk` is one half of an interface clock. Each tick of the strobe therefore carries exactly one data element. A write command supplies a latency in interface clocks, a chop flag, eight data words and a mask byte group per word. The block stores them and, once the latency has elapsed, drives the burst. The strobe is framed by a one-clock low preamble and a half-clock low postamble.

Commands may be issued while earlier ones are still waiting out their latency. When a command follows the previous full burst at the minimum command spacing of four interface clocks (eight ticks), its data continues the stream directly. In that case the strobe keeps toggling, and no postamble or preamble appears between the two bursts. Between bursts every output enable is low, so the pad drivers leave the lines floating.

Top module: `wrburst_phy`

## Requirements
- R1: While reset is asserted and until the first command, `dq_oe` and `strobe_oe` are low and `dq_out`, `dm_out` and `strobe_out` are zero.
- R2: A command sampled on clock edge t0 with latency WL puts its element 0 on `dq_out` with `dq_oe` high in the tick following edge t0+2*WL, and `strobe_out` is high in that tick (the first valid rising strobe edge).
- R3: Element k of a burst, taken from `cmd_data[k*DW +: DW]`, appears in the tick following edge t0+2*WL+k. `strobe_out` is high for even k and low for odd k, so the strobe changes level on every element.
- R4: In the two ticks before the first element of a burst that does not directly continue a previous one, `strobe_oe` is high, `strobe_out` is low and `dq_oe` is low.
- R5: In the tick after the last element of a burst that no burst directly follows, `strobe_oe` is high and `strobe_out` is low. After that tick `strobe_oe` falls unless a preamble follows.
- R6: `dm_out` carries `cmd_mask[k*NB +: NB]` in the same tick as element k. Bit b covers `dq_out[8*b+7:8*b]`, and a 1 marks that byte as not to be written.
- R7: Outside data ticks `dq_oe` is low and `dq_out` and `dm_out` are zero. Changes of `cmd_data` or `cmd_mask` without a command do not affect any output, including a burst already accepted.
- R8: With `cmd_chop` = 1 only elements 0 to 3 are driven, followed by the postamble.
- R9: A command issued exactly eight ticks after a full-length one produces a gapless stream: the tick after the last element of the first burst carries element 0 of the second, and the strobe keeps alternating.
- R10: Any latency from WL_MIN to WL_MAX is accepted. Commands spaced at least eight ticks apart, with up to WL_MAX/4+1 waiting, are driven in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the interface clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_wr | input | 1 | One-tick write command pulse |
| cmd_chop | input | 1 | 1 selects a four-element burst, 0 an eight-element burst |
| cmd_wl | input | WLW | Write latency in interface clocks, sampled with the command |
| cmd_data | input | 8*DW | Eight data elements; element k at bits k*DW upward |
| cmd_mask | input | 8*NB | Byte mask per element; 1 blocks the byte |
| dq_out | output | DW | Data lane value |
| dq_oe | output | 1 | Data and mask lane output enable |
| dm_out | output | NB | Mask lane value |
| strobe_out | output | 1 | Data strobe level |
| strobe_oe | output | 1 | Data strobe output enable |

## Verification
The hardest situation to reach is the one where the postamble of one burst, the idle gap and the preamble of the next burst interact. This happens when a chopped burst is followed eight ticks later by a full one, when bursts are spaced by one or two ticks more than the minimum, and when five commands are stacked at the largest latency so that several sit waiting in storage at once. The stimulus reaches these cases by issuing command trains with exact tick spacing at several latencies. The bench scrambles the data inputs right after every command, so stale capture shows up as a data mismatch. A behavioural tick-indexed schedule predicts every output, and the bench compares all outputs against it on every tick.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  // elements in a full burst and in a chopped burst
  localparam int unsigned ELEMS      = 8;
  localparam int unsigned CHOP_ELEMS = 4;
  localparam int unsigned ECW        = $clog2(ELEMS);
endpackage

// File: rtl/wrb_lat_line.sv
// Command token delay line: a token written at tap 2*WL-1 reaches tap 0
// one tick before the first data tick of its burst.
module wrb_lat_line #(
  parameter int unsigned WL_MIN = 5,
  parameter int unsigned WL_MAX = 16,
  parameter int unsigned WLW    = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [WLW-1:0] wl,
  output logic           tap0,
  output logic           tap1,
  output logic           tap2
);
  localparam int unsigned TOKN = 2 * WL_MAX;
  localparam int unsigned TW   = $clog2(TOKN);

  logic [TOKN-1:0] tok_q, tok_d;
  logic [WLW-1:0]  wl_c;
  logic [WLW:0]    tap_full;
  logic [TW-1:0]   tap_idx;

  always_comb begin
    if (wl < WLW'(WL_MIN))      wl_c = WLW'(WL_MIN);
    else if (wl > WLW'(WL_MAX)) wl_c = WLW'(WL_MAX);
    else                        wl_c = wl;
    tap_full = {wl_c, 1'b0} - (WLW+1)'(1);
    tap_idx  = tap_full[TW-1:0];
  end

  always_comb begin
    tok_d = tok_q >> 1;
    if (push) tok_d[tap_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok_q <= '0;
    else        tok_q <= tok_d;
  end

  assign tap0 = tok_q[0];
  assign tap1 = tok_q[1];
  assign tap2 = tok_q[2];
endmodule

// File: rtl/wrb_burst_store.sv
// In-order storage of captured burst payloads, one entry per waiting command.
module wrb_burst_store
  import wrb_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned NB    = 2,
  parameter int unsigned DEPTH = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [ELEMS*DW-1:0] in_data,
  input  logic [ELEMS*NB-1:0] in_mask,
  input  logic                in_chop,
  input  logic                pop,
  output logic [ELEMS*DW-1:0] head_data,
  output logic [ELEMS*NB-1:0] head_mask,
  output logic                head_chop
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [ELEMS*DW-1:0] ent_data [DEPTH];
  logic [ELEMS*NB-1:0] ent_mask [DEPTH];
  logic [DEPTH-1:0]    ent_chop;
  logic [DEPTH-1:0]    ent_we;
  logic [PW-1:0]       wp_q, wp_d, rp_q, rp_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wp_d = push ? ptr_inc(wp_q) : wp_q;
    rp_d = pop  ? ptr_inc(rp_q) : rp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      wp_q <= wp_d;
      rp_q <= rp_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign ent_we[g] = push && (wp_q == PW'(g));
    always_ff @(posedge clk) begin
      if (ent_we[g]) begin
        ent_data[g] <= in_data;
        ent_mask[g] <= in_mask;
        ent_chop[g] <= in_chop;
      end
    end
  end

  assign head_data = ent_data[rp_q];
  assign head_mask = ent_mask[rp_q];
  assign head_chop = ent_chop[rp_q];
endmodule

// File: rtl/wrb_lane_seq.sv
// Per-tick pin sequencer: data elements, strobe toggling, preamble/postamble.
module wrb_lane_seq
  import wrb_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned NB = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                near,
  input  logic [ELEMS*DW-1:0] head_data,
  input  logic [ELEMS*NB-1:0] head_mask,
  input  logic                head_chop,
  output logic                pop,
  output logic [DW-1:0]       dq,
  output logic [NB-1:0]       dm,
  output logic                dq_oe,
  output logic                dqs,
  output logic                dqs_oe
);
  logic [ELEMS*DW-1:0] pend_q, pend_d;
  logic [ELEMS*NB-1:0] mpend_q, mpend_d;
  logic [ECW-1:0]      cnt_q, cnt_d;
  logic                pend_en;
  logic [DW-1:0]       dq_q, dq_d;
  logic [NB-1:0]       dm_q, dm_d;
  logic                dq_oe_q, dq_oe_d, dqs_q, dqs_d, dqs_oe_q, dqs_oe_d;

  always_comb begin
    pop      = 1'b0;
    pend_en  = 1'b0;
    pend_d   = pend_q;
    mpend_d  = mpend_q;
    cnt_d    = cnt_q;
    dq_d     = '0;
    dm_d     = '0;
    dq_oe_d  = 1'b0;
    dqs_d    = 1'b0;
    dqs_oe_d = 1'b0;
    if (cnt_q != '0) begin
      // R3: next element on the next strobe edge
      pend_en  = 1'b1;
      dq_d     = pend_q[DW-1:0];
      dm_d     = mpend_q[NB-1:0];
      dq_oe_d  = 1'b1;
      dqs_oe_d = 1'b1;
      dqs_d    = ~dqs_q;
      pend_d   = pend_q >> DW;
      mpend_d  = mpend_q >> NB;
      cnt_d    = cnt_q - ECW'(1);
    end else if (start) begin
      // element 0 with the rising strobe edge
      pop      = 1'b1;
      pend_en  = 1'b1;
      dq_d     = head_data[DW-1:0];
      dm_d     = head_mask[NB-1:0];
      dq_oe_d  = 1'b1;
      dqs_oe_d = 1'b1;
      dqs_d    = 1'b1;
      pend_d   = head_data >> DW;
      mpend_d  = head_mask >> NB;
      cnt_d    = head_chop ? ECW'(CHOP_ELEMS-1) : ECW'(ELEMS-1);
    end else if (near || dq_oe_q) begin
      // preamble ahead of a burst, or postamble after the last element
      dqs_oe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mpend_q <= '0;
      cnt_q   <= '0;
    end else if (pend_en) begin
      pend_q  <= pend_d;
      mpend_q <= mpend_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q     <= '0;
      dm_q     <= '0;
      dq_oe_q  <= 1'b0;
      dqs_q    <= 1'b0;
      dqs_oe_q <= 1'b0;
    end else begin
      dq_q     <= dq_d;
      dm_q     <= dm_d;
      dq_oe_q  <= dq_oe_d;
      dqs_q    <= dqs_d;
      dqs_oe_q <= dqs_oe_d;
    end
  end

  assign dq     = dq_q;
  assign dm     = dm_q;
  assign dq_oe  = dq_oe_q;
  assign dqs    = dqs_q;
  assign dqs_oe = dqs_oe_q;
endmodule

// File: rtl/wrburst_phy.sv
module wrburst_phy
  import wrb_pkg::*;
#(
  parameter int unsigned DW     = 16,
  parameter int unsigned NB     = DW / 8,
  parameter int unsigned WL_MIN = 5,
  parameter int unsigned WL_MAX = 16,
  parameter int unsigned TCCD   = 4,
  parameter int unsigned WLW    = $clog2(WL_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic                cmd_chop,
  input  logic [WLW-1:0]      cmd_wl,
  input  logic [ELEMS*DW-1:0] cmd_data,
  input  logic [ELEMS*NB-1:0] cmd_mask,
  output logic [DW-1:0]       dq_out,
  output logic                dq_oe,
  output logic [NB-1:0]       dm_out,
  output logic                strobe_out,
  output logic                strobe_oe
);
  localparam int unsigned STORE_DEPTH = WL_MAX / TCCD + 2;

  logic rst_meta_q, rst_sync_q;
  logic tap0, tap1, tap2, pop;
  logic [ELEMS*DW-1:0] head_data;
  logic [ELEMS*NB-1:0] head_mask;
  logic head_chop;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  wrb_lat_line #(.WL_MIN(WL_MIN), .WL_MAX(WL_MAX), .WLW(WLW)) u_lat (
    .clk(clk), .rst_n(rst_sync_q), .push(cmd_wr), .wl(cmd_wl),
    .tap0(tap0), .tap1(tap1), .tap2(tap2)
  );

  wrb_burst_store #(.DW(DW), .NB(NB), .DEPTH(STORE_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_q), .push(cmd_wr),
    .in_data(cmd_data), .in_mask(cmd_mask), .in_chop(cmd_chop),
    .pop(pop), .head_data(head_data), .head_mask(head_mask),
    .head_chop(head_chop)
  );

  wrb_lane_seq #(.DW(DW), .NB(NB)) u_seq (
    .clk(clk), .rst_n(rst_sync_q), .start(tap0), .near(tap1 | tap2),
    .head_data(head_data), .head_mask(head_mask), .head_chop(head_chop),
    .pop(pop), .dq(dq_out), .dm(dm_out), .dq_oe(dq_oe),
    .dqs(strobe_out), .dqs_oe(strobe_oe)
  );
endmodule

// File: rtl/wrburst_phy_chk.sv
module wrburst_phy_chk #(
  parameter int unsigned DW   = 16,
  parameter int unsigned NB   = 2,
  parameter int unsigned TCCD = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr,
  input logic [DW-1:0] dq_out,
  input logic          dq_oe,
  input logic [NB-1:0] dm_out,
  input logic          strobe_out,
  input logic          strobe_oe
);
  localparam int unsigned GAP = 2 * TCCD - 1;
  localparam int unsigned GW  = $clog2(GAP + 1);

  logic [GW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_q <= GW'(GAP);
    else if (cmd_wr)            since_q <= '0;
    else if (since_q != GW'(GAP)) since_q <= since_q + GW'(1);
  end

  // R10: commands respect the minimum spacing
  a_r10_cmd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> since_q == GW'(GAP));

  a_r7_data_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> strobe_oe);

  a_r7_quiet_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0) && (dm_out == '0));

  a_r3_strobe_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> (strobe_out != $past(strobe_out)));

  a_r4_preamble_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(strobe_oe) && !$past(strobe_out) && strobe_out));

  a_r5_postamble_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (strobe_oe && !strobe_out));

  a_r5_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_oe) |-> !$past(strobe_out));
endmodule

bind wrburst_phy wrburst_phy_chk #(.DW(DW), .NB(NB), .TCCD(TCCD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .dq_out(dq_out), .dq_oe(dq_oe),
  .dm_out(dm_out), .strobe_out(strobe_out), .strobe_oe(strobe_oe)
);

// File: tb/wrburst_phy_test.sv
`timescale 1ns/1ps
module wrburst_phy_test;
  localparam int DW = 16;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_wr = 1'b0;
  logic          cmd_chop = 1'b0;
  logic [4:0]    cmd_wl = 5'd5;
  logic [127:0]  cmd_data = '0;
  logic [15:0]   cmd_mask = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [NB-1:0] dm_out;
  logic          strobe_out;
  logic          strobe_oe;

  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;
  bit running = 1'b0;
  bit in_rst = 1'b1;

  // tick-indexed schedule: 0 idle, 1 strobe low, 2 data
  int          exp_kind [int];
  logic [15:0] exp_dq   [int];
  logic [1:0]  exp_dm   [int];
  bit          exp_dqs  [int];
  string       exp_tag  [int];

  always #4 clk = ~clk;   // 125 MHz

  wrburst_phy uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_chop(cmd_chop),
    .cmd_wl(cmd_wl), .cmd_data(cmd_data), .cmd_mask(cmd_mask),
    .dq_out(dq_out), .dq_oe(dq_oe), .dm_out(dm_out),
    .strobe_out(strobe_out), .strobe_oe(strobe_oe)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tg, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s tick %0d: actual %h expected %h", tg, what, cyc, act, exp);
    end
  endtask

  task automatic sched(int t0, int wl, bit chop, logic [127:0] d, logic [15:0] m, string tg);
    int n = chop ? 4 : 8;
    int b = t0 + 2 * wl;
    for (int p = b - 2; p < b; p++)
      if (!(exp_kind.exists(p) && exp_kind[p] == 2)) begin
        exp_kind[p] = 1; exp_tag[p] = "R4";
      end
    for (int k = 0; k < n; k++) begin
      exp_kind[b+k] = 2;
      exp_dq[b+k]   = d[k*16 +: 16];
      exp_dm[b+k]   = m[k*2 +: 2];
      exp_dqs[b+k]  = (k % 2 == 0);
      exp_tag[b+k]  = (k == 0) ? tg : ((tg == "R2") ? "R3" : tg);
    end
    if (!(exp_kind.exists(b+n) && exp_kind[b+n] == 2)) begin
      exp_kind[b+n] = 1; exp_tag[b+n] = "R5";
    end
  endtask

  // called at a falling edge; command sampled on the next rising edge
  task automatic issue(int wl, bit chop, string tg);
    logic [127:0] d;
    logic [15:0]  m;
    d = {$urandom, $urandom, $urandom, $urandom};
    m = 16'($urandom);
    cmd_wr = 1'b1; cmd_chop = chop; cmd_wl = 5'(wl);
    cmd_data = d; cmd_mask = m;
    sched(cyc + 1, wl, chop, d, m, tg);
    @(negedge clk);
    cmd_wr = 1'b0;
    cmd_data = ~d;          // R7: later input changes must not leak in
    cmd_mask = ~m;
  endtask

  task automatic gap(int n);
    repeat (n) @(negedge clk);
  endtask

  // compare every tick against the schedule
  always @(negedge clk) begin
    if (running) begin
      int kind;
      string tg;
      kind = exp_kind.exists(cyc) ? exp_kind[cyc] : 0;
      tg   = in_rst ? "R1" : (exp_tag.exists(cyc) ? exp_tag[cyc] : "R7");
      chk(tg, "dq_oe", 32'(dq_oe), 32'(kind == 2));
      chk(tg, "strobe_oe", 32'(strobe_oe), 32'(kind != 0));
      if (kind == 2) begin
        chk(tg, "strobe_out", 32'(strobe_out), 32'(exp_dqs[cyc]));
        chk(tg, "dq_out", 32'(dq_out), 32'(exp_dq[cyc]));
        chk("R6", "dm_out", 32'(dm_out), 32'(exp_dm[cyc]));
      end else begin
        chk(tg, "strobe_out", 32'(strobe_out), 32'd0);
        chk(in_rst ? "R1" : "R7", "dq_out", 32'(dq_out), 32'd0);
        chk(in_rst ? "R1" : "R7", "dm_out", 32'(dm_out), 32'd0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at tick %0d", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    running = 1'b1;
    gap(4);                       // R1: reset state checked each tick
    rst_n = 1'b1;
    gap(4);
    in_rst = 1'b0;
    // R7: inputs wiggle with no command
    for (int i = 0; i < 20; i++) begin
      cmd_data = {$urandom, $urandom, $urandom, $urandom};
      cmd_mask = 16'($urandom);
      @(negedge clk);
    end
    // R2 R3 R6: single full burst at minimum latency
    issue(5, 1'b0, "R2"); gap(40);
    // R8: chopped burst
    issue(7, 1'b1, "R8"); gap(40);
    // R9: three full bursts back to back
    issue(6, 1'b0, "R2"); gap(7);
    issue(6, 1'b0, "R9"); gap(7);
    issue(6, 1'b0, "R9"); gap(40);
    // R8: chopped pair at minimum spacing (postamble, idle, preamble)
    issue(5, 1'b1, "R8"); gap(7);
    issue(5, 1'b1, "R8"); gap(40);
    // R4 R5: spacing one and two ticks above minimum
    issue(8, 1'b0, "R2"); gap(8);
    issue(8, 1'b0, "R2"); gap(9);
    issue(8, 1'b0, "R2"); gap(40);
    // R10: largest latency, five commands in flight
    for (int i = 0; i < 5; i++) begin
      issue(16, 1'b0, (i == 0) ? "R10" : "R9");
      gap(7);
    end
    gap(50);
    // R9 R8: mixed lengths back to back
    issue(10, 1'b0, "R2"); gap(7);
    issue(10, 1'b1, "R9"); gap(7);
    issue(10, 1'b0, "R8"); gap(7);
    issue(10, 1'b0, "R9"); gap(50);
    // R7: inputs wiggle again after all traffic
    for (int i = 0; i < 20; i++) begin
      cmd_data = {$urandom, $urandom, $urandom, $urandom};
      @(negedge clk);
    end
    running = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule